// File: doc/BRIEF.md
# Masked Search Memory with Highest-Index Priority

This block is a synchronous content-addressable store of `DEPTH` words, each `WIDTH` bits wide (512 by 64 by default). It works as an ordinary addressed memory: a command stores a word at an address or fetches one back. A search strobe compares a key against every stored word at once. A per-bit care mask decides which bit positions take part in that comparison. Rows that have never been written, or that have been invalidated, never match.

A priority stage reduces the per-row hits to one result. The result is a found flag and the index of the matching row with the largest address. It is registered, so it appears one clock after the search strobe and then holds until the next search. The same command port also loads the care mask and invalidates single rows. The search strobe is a separate input, so a search can share a cycle with a command. A write always wins that conflict.

Top module: `masked_cam`

## Requirements
- R1: Command code 2 (write) stores `wdata` at `addr` and marks that row valid. Command code 1 (read) returns the stored word on `rdata` one clock later. `rdata` holds between reads.
- R2: A search reports a valid row as matching only when every compared bit of the stored word equals the same bit of `key`. A single differing compared bit clears that row's hit.
- R3: Command code 4 loads `wdata` into the care mask. A mask bit of 1 compares that position, and a mask bit of 0 makes that position match regardless of its value.
- R4: Command code 3 (invalidate) clears the valid flag of the row at `addr`. An invalid row never matches.
- R5: When several rows match, `match_idx` gives the highest matching address.
- R6: `match_found` and `match_idx` update on the clock edge that samples `search` high, and they hold their value until the next accepted search.
- R7: A search that finds no valid matching row drives `match_found` to 0 and `match_idx` to 0. A match on row 0 gives `match_found` 1 with `match_idx` 0.
- R8: When `search` is high in the same cycle as a write command, the write is performed, the search is dropped, and the search outputs keep their previous value.
- R9: While `rst_n` is low at a clock edge, all valid flags clear, the care mask becomes all ones, and `rdata`, `match_found` and `match_idx` become 0.
- R10: A search in the same cycle as an invalidate or a mask load sees the valid flags and the mask as they were before that cycle's command. Codes 0, 5, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd | input | 3 | Command: 0 idle, 1 read, 2 write, 3 invalidate, 4 load mask |
| addr | input | 9 | Row address for read, write and invalidate |
| wdata | input | 64 | Write data, or new mask for command 4 |
| search | input | 1 | Search strobe |
| key | input | 64 | Search key |
| rdata | output | 64 | Registered read data |
| match_found | output | 1 | Registered: at least one valid row matched |
| match_idx | output | 9 | Registered: highest matching row, 0 on a miss |

## Verification
A search and a command can fall in the same cycle, because the search strobe is separate from the command code. The bench raises the strobe together with a write to a row that would become the new highest match. It expects the write to land and the search outputs to stay as they were, and a later plain search must then find the new row. It also pairs a search with an invalidate of the current winner, and with a mask load. In both cases the result it expects comes from the reference state before that cycle's command.

// File: rtl/cam_pkg.sv
// Package: command codes shared by the search memory and its bench.
// Assumes a three-bit command field; unlisted codes are treated as idle.
package cam_pkg;
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_INVAL = 3'd3,
        OP_MASK  = 3'd4
    } cam_op_e;
endpackage

// File: rtl/cam_match_row.sv
// Module: one row comparator. Raises hit when the row is valid and every
// bit selected by care agrees between the stored word and the key.
// Assumes care=1 means "compare this bit".
module cam_match_row #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] word,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] care,
    input  logic             valid,
    output logic             hit
);
    // Purpose: masked equality, gated by the valid flag.
    always_comb begin
        hit = valid && (((word ^ key) & care) == '0);
    end
endmodule

// File: rtl/cam_prio_enc.sv
// Module: priority encoder favouring the highest set input.
// Assumes idx is 0 when no input is set.
module cam_prio_enc #(
    parameter int N  = 512,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Purpose: the last set bit in an ascending scan wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/masked_cam.sv
// Module: masked content-addressable memory with highest-index priority.
// Commands come in on cmd; the search strobe is separate, and a write
// command suppresses a search in the same cycle. All searches use the
// state that was current before the cycle's command takes effect.
module masked_cam
    import cam_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int WIDTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             search,
    input  logic [WIDTH-1:0] key,
    output logic [WIDTH-1:0] rdata,
    output logic             match_found,
    output logic [AW-1:0]    match_idx
);
    cam_op_e          op;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [WIDTH-1:0] care_q;
    logic [DEPTH-1:0] hit_vec;
    logic             any_hit;
    logic [AW-1:0]    win_idx;
    logic             search_fire;

    // Purpose: decode the command bus and the search acceptance.
    always_comb begin
        op          = cam_op_e'(cmd);
        search_fire = search && (op != OP_WRITE);
    end

    // Purpose: word storage, written on the write command (not reset).
    always_ff @(posedge clk) begin
        if (op == OP_WRITE) begin
            mem_q[addr] <= wdata;
        end
    end

    // Purpose: valid flags and the care mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            care_q  <= '1;
        end else begin
            case (op)
                OP_WRITE: valid_q[addr] <= 1'b1;
                OP_INVAL: valid_q[addr] <= 1'b0;
                OP_MASK:  care_q        <= wdata;
                default:  ;
            endcase
        end
    end

    // Purpose: one comparator per row.
    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        cam_match_row #(.WIDTH(WIDTH)) u_row (
            .word  (mem_q[r]),
            .key   (key),
            .care  (care_q),
            .valid (valid_q[r]),
            .hit   (hit_vec[r])
        );
    end

    cam_prio_enc #(.N(DEPTH), .IW(AW)) u_prio (
        .hits (hit_vec),
        .any  (any_hit),
        .idx  (win_idx)
    );

    // Purpose: register the search result on an accepted search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_found <= 1'b0;
            match_idx   <= '0;
        end else if (search_fire) begin
            match_found <= any_hit;
            match_idx   <= win_idx;
        end
    end

    // Purpose: registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (op == OP_READ) begin
            rdata <= mem_q[addr];
        end
    end

    // R1
    write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> valid_q[$past(addr)]);

    // R4
    inval_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INVAL) |=> !valid_q[$past(addr)]);

    // R7
    miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_found |-> (match_idx == '0));

    // R7
    no_hit_reports_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (search_fire && (hit_vec == '0)) |=> !match_found);

    // R8
    write_blocks_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE && search) |=> ($stable(match_found) && $stable(match_idx)));

    // R6
    result_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !search |=> ($stable(match_found) && $stable(match_idx)));
endmodule

// File: tb/masked_cam_bench.sv
`timescale 1ns/1ps
module masked_cam_bench;
    localparam int DEPTH = 512;
    localparam int WIDTH = 64;
    localparam int AW    = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cmd = 3'd0;
    logic [AW-1:0]    addr = '0;
    logic [WIDTH-1:0] wdata = '0;
    logic             search = 1'b0;
    logic [WIDTH-1:0] key = '0;
    logic [WIDTH-1:0] rdata;
    logic             match_found;
    logic [AW-1:0]    match_idx;

    int checks = 0;
    int errors = 0;

    logic [WIDTH-1:0] ref_mem [DEPTH];
    logic [DEPTH-1:0] ref_valid;
    logic [DEPTH-1:0] ref_written;
    logic [WIDTH-1:0] ref_care;
    logic             exp_found;
    logic [AW-1:0]    exp_idx;
    logic [WIDTH-1:0] exp_rdata;
    logic [WIDTH-1:0] pool [4];

    always #2 clk = ~clk;

    masked_cam u_masked_cam (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .wdata(wdata),
        .search(search), .key(key), .rdata(rdata),
        .match_found(match_found), .match_idx(match_idx)
    );

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference search: highest valid row whose compared bits agree.
    task automatic ref_search(input logic [WIDTH-1:0] k);
        exp_found = 1'b0;
        exp_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ref_valid[i] && (((ref_mem[i] ^ k) & ref_care) == '0)) begin
                exp_found = 1'b1;
                exp_idx   = AW'(i);
            end
        end
    endtask

    task automatic step(input logic [2:0] c, input logic [AW-1:0] a,
                        input logic [WIDTH-1:0] d, input logic s,
                        input logic [WIDTH-1:0] k, input string tag);
        @(negedge clk);
        cmd = c; addr = a; wdata = d; search = s; key = k;
        if (s && c != 3'd2) ref_search(k);
        if (c == 3'd1) exp_rdata = ref_mem[a];
        case (c)
            3'd2: begin ref_mem[a] = d; ref_valid[a] = 1'b1; ref_written[a] = 1'b1; end
            3'd3: ref_valid[a] = 1'b0;
            3'd4: ref_care = d;
            default: ;
        endcase
        @(posedge clk);
        #1;
        cmd = 3'd0; search = 1'b0;
        @(negedge clk);
        chk(tag, "rdata", rdata, exp_rdata);
        chk(tag, "match_found", {63'd0, match_found}, {63'd0, exp_found});
        chk(tag, "match_idx", {55'd0, match_idx}, {55'd0, exp_idx});
    endtask

    initial begin
        logic [WIDTH-1:0] va, vb;
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        ref_valid = '0; ref_written = '0; ref_care = '1;
        exp_found = 1'b0; exp_idx = '0; exp_rdata = '0;
        for (int i = 0; i < 4; i++) pool[i] = {$urandom, $urandom};
        va = 64'hA5A5_0F0F_1234_5678;
        vb = 64'h0000_FFFF_0000_FFFE;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9: reset outputs
        chk("R9", "rdata", rdata, '0);
        chk("R9", "match_found", {63'd0, match_found}, 64'd0);
        chk("R9", "match_idx", {55'd0, match_idx}, 64'd0);

        step(3'd0, 9'd0, '0, 1'b1, '0, "R9");            // no valid rows
        step(3'd2, 9'd3, va, 1'b0, '0, "R1");
        step(3'd1, 9'd3, '0, 1'b0, '0, "R1");            // read back
        step(3'd0, 9'd0, '0, 1'b1, va, "R2");            // hit row 3
        step(3'd0, 9'd0, '0, 1'b1, va ^ 64'h1, "R2");    // one bit off, full mask
        step(3'd0, 9'd0, '0, 1'b0, '0, "R6");            // result held
        step(3'd4, 9'd0, ~64'h1, 1'b0, '0, "R3");
        step(3'd0, 9'd0, '0, 1'b1, va ^ 64'h1, "R3");    // masked bit ignored
        step(3'd4, 9'd0, '1, 1'b0, '0, "R3");
        step(3'd2, 9'd511, va, 1'b0, '0, "R1");
        step(3'd2, 9'd10, va, 1'b0, '0, "R1");
        step(3'd0, 9'd0, '0, 1'b1, va, "R5");            // 511 wins
        step(3'd3, 9'd511, '0, 1'b0, '0, "R4");
        step(3'd0, 9'd0, '0, 1'b1, va, "R5");            // 10 wins
        step(3'd3, 9'd10, '0, 1'b0, '0, "R4");
        step(3'd3, 9'd3, '0, 1'b0, '0, "R4");
        step(3'd0, 9'd0, '0, 1'b1, va, "R7");            // miss
        step(3'd2, 9'd0, vb, 1'b0, '0, "R1");
        step(3'd0, 9'd0, '0, 1'b1, vb, "R7");            // hit on row 0
        step(3'd2, 9'd20, vb, 1'b1, vb, "R8");           // write wins
        step(3'd0, 9'd0, '0, 1'b1, vb, "R8");            // now row 20
        step(3'd3, 9'd20, '0, 1'b1, vb, "R10");          // old valid seen
        step(3'd0, 9'd0, '0, 1'b1, vb, "R10");
        step(3'd4, 9'd0, 64'h0, 1'b1, vb ^ 64'hFF, "R10"); // old mask seen
        step(3'd0, 9'd0, '0, 1'b1, 64'h1, "R3");         // all ignored: row 0 only valid
        step(3'd6, 9'd0, 64'h5, 1'b0, '0, "R10");        // unused code
        step(3'd4, 9'd0, '1, 1'b0, '0, "R3");

        for (int n = 0; n < 3000; n++) begin
            int unsigned sel;
            logic [2:0]       c;
            logic [AW-1:0]    a;
            logic [WIDTH-1:0] d, k, p;
            logic             s;
            sel = $urandom % 10;
            a = AW'($urandom);
            d = pool[$urandom % 4];
            p = pool[$urandom % 4];
            case ($urandom % 3)
                0: k = p;
                1: k = p ^ ({$urandom, $urandom} & ~ref_care);
                default: k = {$urandom, $urandom};
            endcase
            s = ($urandom % 2) == 0;
            if (sel < 3) c = 3'd2;
            else if (sel < 5) c = ref_written[a] ? 3'd1 : 3'd0;
            else if (sel < 6) c = 3'd3;
            else if (sel < 7) begin
                c = 3'd4;
                d = (($urandom % 2) == 0) ? '1 : ({$urandom, $urandom} | {$urandom, $urandom});
            end else c = 3'd0;
            if (c == 3'd2 && s) step(c, a, d, s, k, "R8");
            else if (s) step(c, a, d, s, k, "R2");
            else step(c, a, d, s, k, "R1");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule